// File: doc/BRIEF.md
# Capture Memory Readout and Command Controller

This block sits between a byte-wide serial link and the sample memory of a logic capture engine. Host command bytes arrive on a byte-valid port. One code clears the capture engine and the readout state. Another code arms the engine. Each of these commands gives a one-cycle pulse to the engine. Once the engine reports that its capture is complete, the controller reads the whole memory through a synchronous read port and streams it to the transmitter one byte at a time, under a valid/ready handshake. No header is sent.

The stream runs backwards. Memory words go out from the highest address down to address 0. Within each word, the least significant byte goes first. A host that stores each received byte one slot lower in its buffer, starting from the buffer's end, therefore gets the memory image back in its natural order. In that image, each word begins with its repeat-count field and then holds its data field, and both fields are most significant byte first. The memory word is packed as {repeat count, data}, so the count sits in the upper bits. The number of data bytes, the number of count bytes and the memory depth are parameters.

Top module: `capdump_ctrl`

## Requirements
- R1: After reset, tx_valid, mem_ren, dump_done, eng_clear and eng_arm are all low, and the controller is idle.
- R2: A received byte 0x00 drives eng_clear high for exactly the next cycle. The controller returns to idle. If a dump is running, it is aborted: from that next cycle, tx_valid and mem_ren stay low and no dump_done follows.
- R3: A received byte 0x01, while no dump is running, drives eng_arm high for exactly the next cycle and puts the controller in the armed state.
- R4: Received bytes other than 0x00 and 0x01 have no effect. A 0x01 received during a dump has no effect either: no eng_arm pulse, and the byte stream continues unchanged.
- R5: A cap_done pulse starts a dump only while the controller is armed. In the idle state, cap_done is ignored.
- R6: Each word is read exactly once. mem_ren is high for one cycle with mem_addr equal to the word address, and that cycle comes directly before the first byte of the word is offered. Addresses go from DEPTH-1 down to 0. mem_addr does not change while the word's bytes are being sent.
- R7: A dump sends exactly DEPTH*(DATA_BYTES+CNT_BYTES) bytes and no header. For each word, the bytes go out as bits [7:0] first, then bits [15:8], and so on up to the top byte of the word.
- R8: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_byte stays unchanged in the next cycle. The only exception is a clear command, which aborts the dump.
- R9: dump_done is high for exactly one cycle. That cycle comes directly after the cycle in which the transmitter accepted the last byte (address 0, top byte).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A host command byte is present this cycle |
| rx_byte | input | 8 | Host command byte |
| cap_done | input | 1 | Pulse from the capture engine: capture finished |
| eng_clear | output | 1 | One-cycle clear pulse to the capture engine |
| eng_arm | output | 1 | One-cycle arm pulse to the capture engine |
| mem_ren | output | 1 | Read enable for the synchronous sample memory |
| mem_addr | output | ADDR_W | Sample memory read address |
| mem_rdata | input | 8*(DATA_BYTES+CNT_BYTES) | Read data, valid one cycle after mem_ren, held otherwise |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_ready | input | 1 | The transmitter accepts the offered byte this cycle |
| dump_done | output | 1 | One-cycle pulse after the last byte has been accepted |

## Verification
The dump is run three times, each with a different tx_ready pattern:

- tx_ready held high, which shows the minimum per-word cadence, including the read bubble.
- a pseudo-random tx_ready, which shows that bytes are held under stalls and are never skipped or repeated.
- a strictly alternating tx_ready, which lands stalls on the last byte of each word and so tests how the word boundary is handled.

Each run uses a different memory fill, so any error in address order or byte order shows up as a byte mismatch. Further runs cover other cases:

- junk command bytes and cap_done sent while idle, to tell an ignored command apart from a decoded one;
- an arm byte and a junk byte sent during a dump;
- a clear sent partway through a dump, followed by a fresh dump, which shows that the abort leaves no stale address or byte index behind.

// File: rtl/capdump_pkg.sv
package capdump_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CMD_CLEAR = 8'h00;
   localparam logic [BYTE_W-1:0] CMD_ARM   = 8'h01;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ARMED,
      PH_FETCH,
      PH_SEND,
      PH_DONE
   } phase_e;
endpackage

// File: rtl/capdump_cmd.sv
module capdump_cmd
   import capdump_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              arm_allow,
   output logic              cmd_clear,
   output logic              cmd_arm,
   output logic              eng_clear,
   output logic              eng_arm
);
   always_comb begin
      cmd_clear = rx_valid && (rx_byte == CMD_CLEAR);
      cmd_arm   = rx_valid && (rx_byte == CMD_ARM);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eng_clear <= 1'b0;
         eng_arm   <= 1'b0;
      end else begin
         eng_clear <= cmd_clear;
         eng_arm   <= cmd_arm && arm_allow;
      end
   end
endmodule

// File: rtl/capdump_walk.sv
module capdump_walk
   import capdump_pkg::*;
#(
   parameter int DEPTH      = 256,
   parameter int WORD_BYTES = 3,
   parameter int ADDR_W     = 8,
   parameter int BIDX_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_clear,
   input  logic              cmd_arm,
   input  logic              cap_done,
   input  logic              tx_ready,
   output logic              busy,
   output logic              rd_en,
   output logic              send_valid,
   output logic              finished,
   output logic [ADDR_W-1:0] word_addr,
   output logic [BIDX_W-1:0] byte_idx
);
   localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(DEPTH - 1);
   localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(WORD_BYTES - 1);

   phase_e phase;
   logic   last_byte;
   logic   last_word;

   always_comb begin
      last_byte  = (byte_idx == LAST_BYTE);
      last_word  = (word_addr == '0);
      busy       = (phase == PH_FETCH) || (phase == PH_SEND);
      rd_en      = (phase == PH_FETCH);
      send_valid = (phase == PH_SEND);
      finished   = (phase == PH_DONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         word_addr <= '0;
         byte_idx  <= '0;
      end else if (cmd_clear) begin
         phase    <= PH_IDLE;
         byte_idx <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (cmd_arm) phase <= PH_ARMED;
            end
            PH_ARMED: begin
               if (!cmd_arm && cap_done) begin
                  phase     <= PH_FETCH;
                  word_addr <= TOP_ADDR;
               end
            end
            PH_FETCH: begin
               phase    <= PH_SEND;
               byte_idx <= '0;
            end
            PH_SEND: begin
               if (tx_ready) begin
                  if (!last_byte) begin
                     byte_idx <= byte_idx + 1'b1;
                  end else if (last_word) begin
                     phase <= PH_DONE;
                  end else begin
                     word_addr <= word_addr - 1'b1;
                     phase     <= PH_FETCH;
                  end
               end
            end
            PH_DONE: begin
               phase <= cmd_arm ? PH_ARMED : PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/capdump_pick.sv
module capdump_pick
   import capdump_pkg::*;
#(
   parameter int WORD_BYTES = 3,
   parameter int BIDX_W     = 2
) (
   input  logic [WORD_BYTES*BYTE_W-1:0] word,
   input  logic [BIDX_W-1:0]            idx,
   output logic [BYTE_W-1:0]            byte_out
);
   generate
      if (WORD_BYTES == 1) begin : g_single
         logic unused_idx;
         assign unused_idx = ^idx;
         assign byte_out   = word;
      end else begin : g_mux
         always_comb begin
            byte_out = '0;
            for (int i = 0; i < WORD_BYTES; i++) begin
               if (idx == BIDX_W'(i)) byte_out = word[i*BYTE_W +: BYTE_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/capdump_ctrl.sv
module capdump_ctrl
   import capdump_pkg::*;
#(
   parameter int DATA_BYTES = 2,
   parameter int CNT_BYTES  = 1,
   parameter int DEPTH      = 256,
   localparam int WORD_BYTES = DATA_BYTES + CNT_BYTES,
   localparam int WORD_W     = WORD_BYTES * BYTE_W,
   localparam int ADDR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int BIDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              cap_done,
   output logic              eng_clear,
   output logic              eng_arm,
   output logic              mem_ren,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   input  logic              tx_ready,
   output logic              dump_done
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("capdump_ctrl: DEPTH must be at least 2");
      end
      if (DATA_BYTES < 1) begin : g_bad_data
         $error("capdump_ctrl: DATA_BYTES must be at least 1");
      end
      if (CNT_BYTES < 1) begin : g_bad_cnt
         $error("capdump_ctrl: CNT_BYTES must be at least 1");
      end
   endgenerate

   logic              cmd_clear;
   logic              cmd_arm;
   logic              busy;
   logic [BIDX_W-1:0] byte_idx;

   capdump_cmd u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .arm_allow (!busy),
      .cmd_clear (cmd_clear),
      .cmd_arm   (cmd_arm),
      .eng_clear (eng_clear),
      .eng_arm   (eng_arm)
   );

   capdump_walk #(
      .DEPTH      (DEPTH),
      .WORD_BYTES (WORD_BYTES),
      .ADDR_W     (ADDR_W),
      .BIDX_W     (BIDX_W)
   ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_clear  (cmd_clear),
      .cmd_arm    (cmd_arm),
      .cap_done   (cap_done),
      .tx_ready   (tx_ready),
      .busy       (busy),
      .rd_en      (mem_ren),
      .send_valid (tx_valid),
      .finished   (dump_done),
      .word_addr  (mem_addr),
      .byte_idx   (byte_idx)
   );

   capdump_pick #(
      .WORD_BYTES (WORD_BYTES),
      .BIDX_W     (BIDX_W)
   ) u_pick (
      .word     (mem_rdata),
      .idx      (byte_idx),
      .byte_out (tx_byte)
   );
endmodule

// File: rtl/capdump_ctrl_chk.sv
module capdump_ctrl_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [7:0]        rx_byte,
   input logic              eng_clear,
   input logic              eng_arm,
   input logic              mem_ren,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              tx_valid,
   input logic [7:0]        tx_byte,
   input logic              tx_ready,
   input logic              dump_done
);
   logic clr_in;
   assign clr_in = rx_valid && (rx_byte == 8'h00);

   p_clear_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_in |=> (eng_clear && !tx_valid && !mem_ren));

   p_arm_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_arm |-> $past(rx_valid && (rx_byte == 8'h01)));

   p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_valid, mem_ren, dump_done}));

   p_read_then_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ren && !clr_in) |=> (tx_valid && $stable(mem_addr)));

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !clr_in) |=> (tx_valid && $stable(tx_byte)));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dump_done |=> !dump_done);

   p_done_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dump_done |-> $past(tx_valid && tx_ready));
endmodule

bind capdump_ctrl capdump_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_byte   (rx_byte),
   .eng_clear (eng_clear),
   .eng_arm   (eng_arm),
   .mem_ren   (mem_ren),
   .mem_addr  (mem_addr),
   .tx_valid  (tx_valid),
   .tx_byte   (tx_byte),
   .tx_ready  (tx_ready),
   .dump_done (dump_done)
);

// File: tb/capdump_ctrl_test.sv
module capdump_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int DATA_BYTES = 2;
   localparam int CNT_BYTES  = 1;
   localparam int L          = DATA_BYTES + CNT_BYTES;
   localparam int WORD_W     = 8 * L;
   localparam int ADDR_W     = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_valid = 1'b0;
   logic [7:0]        rx_byte = 8'h00;
   logic              cap_done = 1'b0;
   logic              eng_clear, eng_arm, mem_ren, tx_valid, dump_done;
   logic [ADDR_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_rdata = '0;
   logic [7:0]        tx_byte;
   logic              tx_ready = 1'b1;

   logic [WORD_W-1:0] mem [DEPTH];

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit started = 0;

   // reference model state
   int m_ph = 0;            // 0 idle 1 armed 2 fetch 3 send 4 done
   int m_addr = 0;
   int m_bidx = 0;
   bit m_clr = 0;
   bit m_arm = 0;
   bit c0, c1, m_busy;
   byte unsigned m_q[$];
   byte unsigned got[$];
   int n_done = 0;
   int n_arm = 0;
   int n_ren = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   capdump_ctrl #(.DATA_BYTES(DATA_BYTES), .CNT_BYTES(CNT_BYTES), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .cap_done(cap_done), .eng_clear(eng_clear), .eng_arm(eng_arm),
      .mem_ren(mem_ren), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
      .dump_done(dump_done)
   );

   always @(posedge clk) if (mem_ren) mem_rdata <= mem[mem_addr];

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic expected_list(ref byte unsigned lst[$]);
      lst.delete();
      for (int a = DEPTH - 1; a >= 0; a--)
         for (int j = 0; j < L; j++) lst.push_back(mem[a][8*j +: 8]);
   endtask

   task automatic fill(int seed);
      for (int a = 0; a < DEPTH; a++)
         mem[a] = WORD_W'(a * 32'h9E37 + seed * 32'h3B1 + 32'h5A);
   endtask

   // reference model, updated at each rising edge from pre-edge inputs
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_addr = 0; m_bidx = 0; m_clr = 0; m_arm = 0; m_q.delete();
      end else begin
         c0 = rx_valid && (rx_byte == 8'h00);
         c1 = rx_valid && (rx_byte == 8'h01);
         m_busy = (m_ph == 2) || (m_ph == 3);
         m_clr = c0;
         m_arm = c1 && !m_busy;
         if (eng_arm) n_arm++;
         if (mem_ren) n_ren++;
         if (dump_done) n_done++;
         if (c0) begin
            m_ph = 0; m_bidx = 0; m_q.delete();
         end else begin
            case (m_ph)
               0: if (c1) m_ph = 1;
               1: if (!c1 && cap_done) begin
                     expected_list(m_q); m_addr = DEPTH - 1; m_ph = 2;
                  end
               2: begin m_ph = 3; m_bidx = 0; end
               3: if (tx_ready) begin
                     got.push_back(tx_byte);
                     void'(m_q.pop_front());
                     if (m_bidx != L - 1) m_bidx++;
                     else if (m_addr == 0) m_ph = 4;
                     else begin m_addr--; m_ph = 2; end
                  end
               4: m_ph = c1 ? 1 : 0;
               default: m_ph = 0;
            endcase
         end
      end
   end

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (started) begin
         check(tx_valid == (m_ph == 3), "R7", "tx_valid", tx_valid, m_ph == 3);
         check(mem_ren == (m_ph == 2), "R6", "mem_ren", mem_ren, m_ph == 2);
         if (m_ph == 2 || m_ph == 3)
            check(mem_addr == ADDR_W'(m_addr), "R6", "mem_addr", mem_addr, m_addr);
         if (m_ph == 3 && m_q.size() > 0)
            check(tx_byte == m_q[0], "R7", "tx_byte", tx_byte, m_q[0]);
         check(dump_done == (m_ph == 4), "R9", "dump_done", dump_done, m_ph == 4);
         check(eng_clear == m_clr, "R2", "eng_clear", eng_clear, m_clr);
         check(eng_arm == m_arm, "R3 R4", "eng_arm", eng_arm, m_arm);
      end
   end

   // transmitter ready patterns
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
         0: tx_ready <= 1'b1;
         1: tx_ready <= lfsr[3] | lfsr[7];
         default: tx_ready <= ~tx_ready;
      endcase
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      if (cyc > 60000) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected<=60000 cycles", cyc);
         summary();
         $finish;
      end
   end

   task automatic cmd(logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); cap_done = 1'b1;
      @(negedge clk); cap_done = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_done();
      int start = n_done;
      for (int i = 0; i < 2000 && n_done == start; i++) @(negedge clk);
   endtask

   task automatic full_dump(int seed, int mode, string tag);
      byte unsigned exp_l[$];
      int d0;
      fill(seed);
      rdy_mode = mode;
      got.delete();
      d0 = n_done;
      cmd(8'h01);
      pulse_done();
      wait_done();
      expected_list(exp_l);
      check(got.size() == DEPTH * L, tag, "byte count", got.size(), DEPTH * L);
      for (int i = 0; i < exp_l.size() && i < got.size(); i++)
         if (got[i] != exp_l[i]) begin
            check(0, tag, "stream byte", got[i], exp_l[i]);
            break;
         end
      check(n_done == d0 + 1, "R9", "done pulses", n_done - d0, 1);
      check(got.size() > 0 && got[got.size()-1] == mem[0][WORD_W-1 -: 8], "R7", "last byte",
            got.size() > 0 ? got[got.size()-1] : 0, mem[0][WORD_W-1 -: 8]);
   endtask

   initial begin
      int a0, r0, s0;
      fill(1);
      repeat (3) @(negedge clk);
      started = 1;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_valid && !mem_ren && !dump_done && !eng_clear && !eng_arm, "R1", "reset outputs",
            {tx_valid, mem_ren, dump_done, eng_clear, eng_arm}, 0);

      // R4 / R5: junk commands and cap_done while idle
      a0 = n_arm; r0 = n_ren;
      cmd(8'h55);
      cmd(8'h02);
      pulse_done();
      idle(6);
      check(n_arm == a0, "R4", "arm pulses after junk", n_arm - a0, 0);
      check(n_ren == r0 && !tx_valid, "R5", "reads while idle", n_ren - r0, 0);

      // plain dump with ready always high
      full_dump(2, 0, "R7");

      // dump under random stalls with arm and junk injected mid-dump
      fill(3);
      rdy_mode = 1;
      got.delete();
      a0 = n_arm;
      cmd(8'h01);
      pulse_done();
      idle(5);
      cmd(8'h01);
      cmd(8'h07);
      check(n_arm == a0 + 1, "R4", "arm during dump", n_arm - a0, 1);
      wait_done();
      begin
         byte unsigned e[$];
         expected_list(e);
         check(got == e, "R8", "stream under stalls", got.size(), e.size());
      end

      // abort mid-dump with clear
      fill(4);
      rdy_mode = 0;
      got.delete();
      s0 = n_done;
      cmd(8'h01);
      pulse_done();
      idle(6);
      cmd(8'h00);
      idle(8);
      check(!tx_valid && !mem_ren, "R2", "outputs after abort", {tx_valid, mem_ren}, 0);
      check(n_done == s0, "R2", "done after abort", n_done - s0, 0);
      check(got.size() < DEPTH * L, "R2", "bytes before abort", got.size(), DEPTH * L);

      // cap_done after clear without re-arm must be ignored
      r0 = n_ren;
      pulse_done();
      idle(4);
      check(n_ren == r0, "R5", "reads after clear", n_ren - r0, 0);

      // fresh dump after abort with alternating ready
      full_dump(5, 2, "R6");

      idle(4);
      summary();
      $finish;
   end
endmodule